// File: doc/BRIEF.md
# Bit Permutation Unit (generalized reverse, OR-combine, shuffle)

This block rearranges the bits of one operand under control of a second. It offers four operations on 64-bit or 32-bit data: generalized reverse, generalized OR-combine, perfect shuffle and the inverse of the shuffle. The low bits of the control operand form an amount, and each bit of that amount switches one butterfly stage on. The reverse and OR-combine stages swap adjacent fields of size 1, 2, 4, 8, 16 and 32 bits. The shuffle stages move the inner quarters of fields. The shuffle runs its stages from the widest field down, and the inverse shuffle runs them from the narrowest field up.

A request is accepted when `in_valid` is high. The result is registered and appears one clock later with `out_valid`. In word mode, only the low 32 bits of the data are used and the upper half of the result is zero. Any further extension of the result, and any flag generation, is handled outside this block.

Top module: `bitperm_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is 0 and `out_result` is 0.
- R2: A request with `in_valid` high is reported one clock later, with `out_valid` high and the result. A cycle with `in_valid` low gives `out_valid` low in the next cycle, and `out_result` holds its last value.
- R3: Generalized reverse (`in_op` = 0): result bit i equals source bit (i XOR amount), where amount is `in_ctrl[5:0]` for doubleword and `in_ctrl[4:0]` for word.
- R4: OR-combine (`in_op` = 1) uses the same amount as R3. Result bit i is the OR of every source bit j whose index differs from i only in bit positions that are set in the amount. As a result, every set source bit stays set.
- R5: Shuffle (`in_op` = 2) uses amount bits `in_ctrl[4:0]` (doubleword) or `in_ctrl[3:0]` (word). It applies stages in the order 16, 8, 4, 2, 1. Each enabled stage with distance N and masks L, R maps x to (x & ~(L|R)) | ((x<<N)&L) | ((x>>N)&R). The mask pairs are:
  - N=16: 0x0000ffff00000000 and 0x00000000ffff0000
  - N=8: 0x00ff000000ff0000 and 0x0000ff000000ff00
  - N=4: 0x0f000f000f000f00 and 0x00f000f000f000f0
  - N=2: 0x3030…30 and 0x0c0c…0c
  - N=1: 0x4444…44 and 0x2222…22
- R6: Unshuffle (`in_op` = 3) applies the R5 stages in the order 1, 2, 4, 8, 16. Unshuffling a shuffle result with the same amount gives back the original source.
- R7: With `in_word` high, `in_data[63:32]` is ignored and `out_result[63:32]` is 0.
- R8: Control bits above the active amount field have no effect on the result.
- R9: An amount of zero returns the source unchanged for every operation.
- R10: Reverse, shuffle and unshuffle only move bits, so the number of set bits in the result equals that of the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | 0 reverse, 1 OR-combine, 2 shuffle, 3 unshuffle |
| in_word | input | 1 | 1 selects 32-bit operation on the low half |
| in_data | input | 64 | Source operand |
| in_ctrl | input | 64 | Control operand; its low bits form the amount |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 64 | Permuted result |

## Verification
Two effects can act on the same request: word truncation and masking of the amount field. Setting control bit 5 together with `in_word` provokes both at once. A word shuffle with bit 4 set does the same. The bench sweeps every 6-bit amount under random upper control bits in both widths, so both effects always meet. Each result is judged against an index-based reference that uses only the masked amount and the zero-extended source. A second meeting point is a hold cycle that follows a request directly: the bench checks that the held value is the earlier result, not a fresh computation.

// File: rtl/bitperm_pkg.sv
package bitperm_pkg;
    typedef enum logic [1:0] {
        OP_GREV   = 2'd0,
        OP_GORC   = 2'd1,
        OP_SHFL   = 2'd2,
        OP_UNSHFL = 2'd3
    } perm_op_e;
endpackage

// File: rtl/bitperm_swap_stage.sv
// One butterfly stage of the reverse / OR-combine chain: swaps fields of
// size 2**K, optionally OR-ing the swapped value into the input.
module bitperm_swap_stage #(
    parameter int W = 64,
    parameter int K = 0
) (
    input  logic [W-1:0] x_i,
    input  logic         en_i,
    input  logic         or_mode_i,
    output logic [W-1:0] y_o
);
    localparam int S = 1 << K;

    function automatic logic [W-1:0] low_field_mask();
        logic [W-1:0] m;
        for (int i = 0; i < W; i++) m[i] = (((i >> K) & 1) == 0);
        return m;
    endfunction

    localparam logic [W-1:0] LO = low_field_mask();

    logic [W-1:0] swapped;

    always_comb begin
        swapped = ((x_i & LO) << S) | ((x_i & ~LO) >> S);
        if (!en_i)          y_o = x_i;
        else if (or_mode_i) y_o = x_i | swapped;
        else                y_o = swapped;
    end
endmodule

// File: rtl/bitperm_shuf_stage.sv
// Position P of the shuffle chain. Forward order uses stage SH-1-P,
// reverse order uses stage P; both candidate stages are wired here.
module bitperm_shuf_stage #(
    parameter int W  = 64,
    parameter int SH = 5,
    parameter int P  = 0
) (
    input  logic [W-1:0]  x_i,
    input  logic [SH-1:0] amt_i,
    input  logic          reverse_i,
    output logic [W-1:0]  y_o
);
    localparam int JF = SH - 1 - P;
    localparam int JR = P;

    function automatic logic [W-1:0] shuf_mask(input int j, input bit left);
        logic [W-1:0] m;
        for (int i = 0; i < W; i++) begin
            if (left) m[i] = (((i >> (j + 1)) & 1) == 1) && (((i >> j) & 1) == 0);
            else      m[i] = (((i >> (j + 1)) & 1) == 0) && (((i >> j) & 1) == 1);
        end
        return m;
    endfunction

    localparam logic [W-1:0] LF = shuf_mask(JF, 1'b1);
    localparam logic [W-1:0] RF = shuf_mask(JF, 1'b0);
    localparam logic [W-1:0] LR = shuf_mask(JR, 1'b1);
    localparam logic [W-1:0] RR = shuf_mask(JR, 1'b0);

    logic [W-1:0] fwd_v;
    logic [W-1:0] rev_v;

    always_comb begin
        fwd_v = (x_i & ~(LF | RF)) | ((x_i << (1 << JF)) & LF) | ((x_i >> (1 << JF)) & RF);
        rev_v = (x_i & ~(LR | RR)) | ((x_i << (1 << JR)) & LR) | ((x_i >> (1 << JR)) & RR);
        if (reverse_i) y_o = amt_i[JR] ? rev_v : x_i;
        else           y_o = amt_i[JF] ? fwd_v : x_i;
    end
endmodule

// File: rtl/bitperm_unit.sv
module bitperm_unit #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [1:0]      in_op,
    input  logic            in_word,
    input  logic [XLEN-1:0] in_data,
    input  logic [XLEN-1:0] in_ctrl,
    output logic            out_valid,
    output logic [XLEN-1:0] out_result
);
    import bitperm_pkg::*;

    localparam int LG   = $clog2(XLEN);
    localparam int SH   = LG - 1;
    localparam int HALF = XLEN / 2;

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] res;
    } state_t;

    state_t state_d, state_q;

    perm_op_e        op_sel;
    logic [XLEN-1:0] src;
    logic [LG-1:0]   amt_g;
    logic [SH-1:0]   amt_s;
    logic            or_mode;
    logic            reverse;

    logic [XLEN-1:0] g_x [LG+1];
    logic [XLEN-1:0] s_x [SH+1];

    always_comb begin
        op_sel  = perm_op_e'(in_op);
        src     = in_word ? {{HALF{1'b0}}, in_data[HALF-1:0]} : in_data;
        amt_g   = in_ctrl[LG-1:0];
        amt_s   = in_ctrl[SH-1:0];
        if (in_word) begin
            amt_g[LG-1] = 1'b0;
            amt_s[SH-1] = 1'b0;
        end
        or_mode = (op_sel == OP_GORC);
        reverse = (op_sel == OP_UNSHFL);
    end

    assign g_x[0] = src;
    assign s_x[0] = src;

    for (genvar k = 0; k < LG; k++) begin : g_swap
        bitperm_swap_stage #(.W(XLEN), .K(k)) u_stage (
            .x_i       (g_x[k]),
            .en_i      (amt_g[k]),
            .or_mode_i (or_mode),
            .y_o       (g_x[k+1])
        );
    end

    for (genvar p = 0; p < SH; p++) begin : g_shuf
        bitperm_shuf_stage #(.W(XLEN), .SH(SH), .P(p)) u_stage (
            .x_i       (s_x[p]),
            .amt_i     (amt_s),
            .reverse_i (reverse),
            .y_o       (s_x[p+1])
        );
    end

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.res = (op_sel == OP_GREV || op_sel == OP_GORC) ? g_x[LG] : s_x[SH];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid  = state_q.vld;
    assign out_result = state_q.res;

    // R2: every request yields a strobe in the next cycle
    a_r2_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: idle cycles hold the result
    a_r2_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));

    // R7: word results have a clear upper half
    a_r7_word_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_word |=> out_result[XLEN-1:HALF] == '0);

    // R9: zero amount passes the source through
    a_r9_zero_amount: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ctrl[LG-1:0] == '0 && !in_word |=> out_result == $past(in_data));

    // R4: OR-combine never clears a source bit
    a_r4_gorc_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_op == 2'd1 && !in_word |=> (out_result & $past(in_data)) == $past(in_data));

    // R10: permutations keep the population count
    a_r10_popcount: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_op != 2'd1 && !in_word |=> $countones(out_result) == $countones($past(in_data)));
endmodule

// File: tb/bitperm_unit_tb.sv
module bitperm_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'd0;
    logic        in_word = 1'b0;
    logic [63:0] in_data = '0;
    logic [63:0] in_ctrl = '0;
    logic        out_valid;
    logic [63:0] out_result;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    bitperm_unit #(.XLEN(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_word(in_word), .in_data(in_data), .in_ctrl(in_ctrl),
        .out_valid(out_valid), .out_result(out_result)
    );

    function automatic logic [63:0] ref_grev(input logic [63:0] x, input logic [5:0] a);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) r[i] = x[i ^ int'(a)];
        return r;
    endfunction

    function automatic logic [63:0] ref_gorc(input logic [63:0] x, input logic [5:0] a);
        logic [63:0] r = '0;
        for (int i = 0; i < 64; i++)
            for (int j = 0; j < 64; j++)
                if ((((i ^ j) & ~int'(a)) & 63) == 0 && x[j]) r[i] = 1'b1;
        return r;
    endfunction

    function automatic logic [63:0] stg(input logic [63:0] x, input logic [63:0] l,
                                        input logic [63:0] r, input int n);
        return (x & ~(l | r)) | ((x << n) & l) | ((x >> n) & r);
    endfunction

    function automatic logic [63:0] st_n(input logic [63:0] x, input int j);
        case (j)
            4: return stg(x, 64'h0000ffff00000000, 64'h00000000ffff0000, 16);
            3: return stg(x, 64'h00ff000000ff0000, 64'h0000ff000000ff00, 8);
            2: return stg(x, 64'h0f000f000f000f00, 64'h00f000f000f000f0, 4);
            1: return stg(x, 64'h3030303030303030, 64'h0c0c0c0c0c0c0c0c, 2);
            default: return stg(x, 64'h4444444444444444, 64'h2222222222222222, 1);
        endcase
    endfunction

    function automatic logic [63:0] ref_shfl(input logic [63:0] x, input logic [4:0] a, input bit inv);
        logic [63:0] y = x;
        for (int s = 0; s < 5; s++) begin
            int j = inv ? s : 4 - s;
            if (a[j]) y = st_n(y, j);
        end
        return y;
    endfunction

    function automatic logic [63:0] expect_of(input logic [1:0] op, input bit w,
                                              input logic [63:0] d, input logic [63:0] c);
        logic [63:0] x = w ? {32'h0, d[31:0]} : d;
        logic [5:0]  ag = w ? {1'b0, c[4:0]} : c[5:0];
        logic [4:0]  as = w ? {1'b0, c[3:0]} : c[4:0];
        case (op)
            2'd0: return ref_grev(x, ag);
            2'd1: return ref_gorc(x, ag);
            2'd2: return ref_shfl(x, as, 1'b0);
            default: return ref_shfl(x, as, 1'b1);
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input bit w, input logic [63:0] d, input logic [63:0] c);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_word = w; in_data = d; in_ctrl = c;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    string opname [4] = '{"R3 R10 grev", "R4 R10 gorc", "R5 R10 shfl", "R6 R10 unshfl"};

    initial begin
        logic [63:0] pats [4];
        logic [63:0] held;
        pats[0] = 64'h0123456789abcdef;
        pats[1] = 64'h8000000000000001;
        pats[2] = {$urandom, $urandom};
        pats[3] = {$urandom, $urandom};

        repeat (3) @(negedge clk);
        check("R1 reset valid", {63'h0, out_valid}, 64'h0);
        check("R1 reset result", out_result, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 first cycle valid", {63'h0, out_valid}, 64'h0);

        for (int p = 0; p < 4; p++)
            for (int op = 0; op < 4; op++)
                for (int w = 0; w < 2; w++)
                    for (int a = 0; a < 64; a++) begin
                        logic [63:0] c = {$urandom, $urandom};
                        c[5:0] = a[5:0];
                        issue(op[1:0], w[0], pats[p], c);
                        check({opname[op], w ? " R7 R8 word" : " R8 dword"},
                              out_result, expect_of(op[1:0], w[0], pats[p], c));
                        check("R2 valid", {63'h0, out_valid}, 64'h1);
                        if (w != 0) check("R7 upper zero", {32'h0, out_result[63:32]}, 64'h0);
                        if (a == 0) check("R9 zero amount", out_result,
                                          w ? {32'h0, pats[p][31:0]} : pats[p]);
                    end

        // R6: unshuffle undoes shuffle
        for (int a = 0; a < 32; a++) begin
            logic [63:0] sh;
            issue(2'd2, 1'b0, pats[2], {59'h0, a[4:0]});
            sh = out_result;
            issue(2'd3, 1'b0, sh, {59'h0, a[4:0]});
            check("R6 round trip", out_result, pats[2]);
        end

        // R2: idle cycle holds the last result
        issue(2'd0, 1'b0, pats[0], 64'h3f);
        held = out_result;
        @(negedge clk);
        check("R2 idle valid low", {63'h0, out_valid}, 64'h0);
        in_data = ~pats[0];
        @(negedge clk);
        check("R2 idle hold", out_result, held);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog R2 actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule